// File: doc/BRIEF.md
# Random Bit Stream Health Monitor

This block watches a serial stream of random bits, one bit per cycle when `bit_valid` is high, and applies online statistical health tests to it. Three tests are judged over fixed windows of `WINDOW_BITS` accepted bits, 20,000 by default:
- a count of ones;
- a count of the sixteen 4-bit pattern values;
- a count of runs by length and by bit value.

Two further detectors watch every accepted bit for long stretches of identical values. One fires at 34 equal bits and one at 48 equal bits.

Each test reports on its own output as a single-cycle pulse, which a status register can latch. Deasserting `enable` stops the monitor and discards everything it has gathered, including any unfinished window. A synchronous reset does the same.

Top module: `rng_health_mon`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every fail output is low. Reset clears every window count and the continuous run count.
- R2: A bit is accepted on a rising edge where `enable` and `bit_valid` are both high. Edges without `bit_valid` do not advance the window. Window verdicts appear only as a one-cycle pulse in the cycle after the edge that accepts the last bit of a window.
- R3: `fail_monobit` pulses at the end of a window if the number of ones in it is below 9,655 or above 10,345.
- R4: The window is cut into non-overlapping 4-bit groups, and the earliest bit of each group is the most significant bit of its value. `fail_poker` pulses at the end of the window if any of the 16 value counts lies outside 240 to 385 inclusive.
- R5: Runs are counted separately for zeros and for ones, in the buckets 1, 2, 3, 4, 5 and 6-or-more. The run still open at the last bit is closed and counted. `fail_runs` pulses at the end of the window if any count leaves its inclusive range: length 1 2315..2685, length 2 1114..1386, length 3 527..723, length 4 240..384, lengths 5 and 6+ both 103..209.
- R6: `fail_long_run` pulses in the cycle after the edge that accepts the 34th consecutive equal bit. It pulses once per run, however long the run grows.
- R7: `fail_noise` pulses in the cycle after the edge that accepts the 48th consecutive equal bit. It pulses once per run, separately from `fail_long_run`.
- R8: The continuous run count carries across window boundaries. The window counts start afresh with each new window.
- R9: While `enable` is low, bits are ignored, no output pulses, and all counts are cleared. A partially filled window therefore never yields a verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Monitor enable; low clears all state |
| bit_in | input | 1 | Random bit under test |
| bit_valid | input | 1 | `bit_in` is valid this cycle |
| fail_monobit | output | 1 | Ones-count verdict pulse |
| fail_poker | output | 1 | 4-bit pattern verdict pulse |
| fail_runs | output | 1 | Run-length verdict pulse |
| fail_long_run | output | 1 | 34 equal bits seen |
| fail_noise | output | 1 | 48 equal bits seen |

## Verification
The situation hardest to reach from the ports is a long run that straddles a window boundary. The continuous detector must keep counting across the boundary while the window run counter closes its final run and restarts. The stimulus ends one window with twenty ones and opens the next with twenty more, so the long-run pulse lands on the fourteenth bit of the new window. Windows with gaps in `bit_valid`, a heavily biased window and a strictly alternating window drive the three window tests into both pass and fail. A discarded partial window, followed by `enable` toggling and reset in the middle of a run, checks that stale counts never leak through.

// File: rtl/rhm_pkg.sv
package rhm_pkg;

    localparam int unsigned NIB_BITS    = 4;
    localparam int unsigned NIB_VALS    = 1 << NIB_BITS;
    localparam int unsigned RUN_BUCKETS = 6;

    localparam int unsigned MONO_LO  = 9655;
    localparam int unsigned MONO_HI  = 10345;
    localparam int unsigned POKER_LO = 240;
    localparam int unsigned POKER_HI = 385;

    typedef struct packed {
        int unsigned lo;
        int unsigned hi;
    } span_t;

    typedef struct packed {
        logic monobit;
        logic poker;
        logic runs;
        logic long_run;
        logic noise;
    } alarm_t;

    // Pass range for run bucket b (b = length-1, last bucket is 6 or more)
    function automatic span_t run_span(int unsigned b);
        span_t s;
        case (b)
            0:       s = span_t'{lo: 2315, hi: 2685};
            1:       s = span_t'{lo: 1114, hi: 1386};
            2:       s = span_t'{lo: 527,  hi: 723};
            3:       s = span_t'{lo: 240,  hi: 384};
            default: s = span_t'{lo: 103,  hi: 209};
        endcase
        return s;
    endfunction

    function automatic logic out_of_span(int unsigned v, span_t s);
        return (v < s.lo) || (v > s.hi);
    endfunction

endpackage

// File: rtl/rhm_poker.sv
module rhm_poker
    import rhm_pkg::*;
#(
    parameter int unsigned WINDOW_BITS = 20000
) (
    input  logic clk,
    input  logic clr,
    input  logic acc,
    input  logic bit_i,
    input  logic last,
    output logic fail
);
    localparam int unsigned CNT_W = $clog2(WINDOW_BITS + 1);
    localparam int unsigned PH_W  = $clog2(NIB_BITS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(NIB_BITS - 1);

    logic [NIB_BITS-2:0] shift_q;
    logic [PH_W-1:0]     phase_q;
    logic [NIB_BITS-1:0] nib;
    logic                hit;
    logic [CNT_W-1:0]    cnt   [NIB_VALS];
    logic [CNT_W-1:0]    nxt   [NIB_VALS];
    logic [NIB_VALS-1:0] bad_v;

    assign nib = {shift_q, bit_i};
    assign hit = acc && (phase_q == PH_LAST);

    generate
        for (genvar g = 0; g < NIB_VALS; g++) begin : g_bin
            assign nxt[g] = cnt[g] + {{(CNT_W-1){1'b0}}, (hit && nib == NIB_BITS'(g))};
            assign bad_v[g] = out_of_span(32'(nxt[g]), span_t'{lo: POKER_LO, hi: POKER_HI});
            always_ff @(posedge clk) begin
                if (clr || last) cnt[g] <= '0;
                else if (acc)    cnt[g] <= nxt[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr || last) begin
            shift_q <= '0;
            phase_q <= '0;
        end else if (acc) begin
            shift_q <= {shift_q[NIB_BITS-3:0], bit_i};
            phase_q <= phase_q + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (clr) fail <= 1'b0;
        else     fail <= last && (|bad_v);
    end

    // The window must end on a group boundary
    AST_GROUP_ALIGNED: assert property (@(posedge clk) disable iff (clr)
        last |-> phase_q == PH_LAST); // R4

endmodule

// File: rtl/rhm_runs.sv
module rhm_runs
    import rhm_pkg::*;
#(
    parameter int unsigned WINDOW_BITS = 20000
) (
    input  logic clk,
    input  logic clr,
    input  logic acc,
    input  logic bit_i,
    input  logic last,
    output logic fail
);
    localparam int unsigned CNT_W = $clog2(WINDOW_BITS + 1);
    localparam int unsigned LEN_W = $clog2(RUN_BUCKETS + 1);
    localparam int unsigned NCNT  = 2 * RUN_BUCKETS;
    localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(RUN_BUCKETS);

    logic             prev_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] new_len;
    logic             same, close_a;
    logic [CNT_W-1:0] cnt [NCNT];
    logic [CNT_W-1:0] nxt [NCNT];
    logic [NCNT-1:0]  bad_v;

    assign same    = (len_q != '0) && (bit_i == prev_q);
    assign close_a = acc && (len_q != '0) && !same;
    assign new_len = same ? ((len_q == LEN_SAT) ? len_q : len_q + LEN_W'(1)) : LEN_W'(1);

    generate
        for (genvar g = 0; g < NCNT; g++) begin : g_bkt
            localparam int unsigned VAL = g / RUN_BUCKETS;
            localparam int unsigned BKT = g % RUN_BUCKETS;
            logic inc_a, inc_b;
            // run closed by a change of value
            assign inc_a = close_a && (prev_q == 1'(VAL)) && (len_q == LEN_W'(BKT + 1));
            // run left open at the last bit of the window
            assign inc_b = last && (bit_i == 1'(VAL)) && (new_len == LEN_W'(BKT + 1));
            assign nxt[g] = cnt[g] + {{(CNT_W-1){1'b0}}, inc_a} + {{(CNT_W-1){1'b0}}, inc_b};
            assign bad_v[g] = out_of_span(32'(nxt[g]), run_span(BKT));
            always_ff @(posedge clk) begin
                if (clr || last) cnt[g] <= '0;
                else if (acc)    cnt[g] <= nxt[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (clr || last) begin
            len_q  <= '0;
            prev_q <= 1'b0;
        end else if (acc) begin
            len_q  <= new_len;
            prev_q <= bit_i;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) fail <= 1'b0;
        else     fail <= last && (|bad_v);
    end

    AST_RUN_LEN_CAP: assert property (@(posedge clk) disable iff (clr)
        len_q <= LEN_SAT); // R5

endmodule

// File: rtl/rhm_run_detect.sv
module rhm_run_detect #(
    parameter int unsigned LONG_RUN_LEN = 34,
    parameter int unsigned NOISE_LEN    = 48
) (
    input  logic clk,
    input  logic clr,
    input  logic acc,
    input  logic bit_i,
    output logic fail_long,
    output logic fail_noise
);
    localparam int unsigned W = $clog2(NOISE_LEN + 1);
    localparam logic [W-1:0] LONG_V  = W'(LONG_RUN_LEN);
    localparam logic [W-1:0] NOISE_V = W'(NOISE_LEN);

    logic         prev_q;
    logic [W-1:0] cnt_q, nxt;

    always_comb begin
        if ((cnt_q != '0) && (bit_i == prev_q))
            nxt = (cnt_q == NOISE_V) ? cnt_q : cnt_q + W'(1);
        else
            nxt = W'(1);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q      <= '0;
            prev_q     <= 1'b0;
            fail_long  <= 1'b0;
            fail_noise <= 1'b0;
        end else begin
            fail_long  <= acc && (nxt == LONG_V) && (cnt_q != LONG_V);
            fail_noise <= acc && (nxt == NOISE_V) && (cnt_q != NOISE_V);
            if (acc) begin
                cnt_q  <= nxt;
                prev_q <= bit_i;
            end
        end
    end

    AST_CONT_CAP: assert property (@(posedge clk) disable iff (clr)
        cnt_q <= NOISE_V); // R6
    AST_FLAGS_APART: assert property (@(posedge clk) disable iff (clr)
        !(fail_long && fail_noise)); // R7

endmodule

// File: rtl/rng_health_mon.sv
module rng_health_mon
    import rhm_pkg::*;
#(
    parameter int unsigned WINDOW_BITS  = 20000,
    parameter int unsigned LONG_RUN_LEN = 34,
    parameter int unsigned NOISE_LEN    = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bit_in,
    input  logic bit_valid,
    output logic fail_monobit,
    output logic fail_poker,
    output logic fail_runs,
    output logic fail_long_run,
    output logic fail_noise
);
    localparam int unsigned POS_W = $clog2(WINDOW_BITS);
    localparam int unsigned CNT_W = $clog2(WINDOW_BITS + 1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WINDOW_BITS - 1);

    logic             clr, acc, last;
    logic [POS_W-1:0] pos_q;
    logic [CNT_W-1:0] ones_q, ones_nxt;
    logic             mono_q;
    alarm_t           alarm;

    assign clr      = rst || !enable;
    assign acc      = enable && bit_valid;
    assign last     = acc && (pos_q == LAST_POS);
    assign ones_nxt = ones_q + CNT_W'(bit_in);

    always_ff @(posedge clk) begin
        if (clr) begin
            pos_q  <= '0;
            ones_q <= '0;
            mono_q <= 1'b0;
        end else begin
            mono_q <= last && out_of_span(32'(ones_nxt), span_t'{lo: MONO_LO, hi: MONO_HI});
            if (last) begin
                pos_q  <= '0;
                ones_q <= '0;
            end else if (acc) begin
                pos_q  <= pos_q + POS_W'(1);
                ones_q <= ones_nxt;
            end
        end
    end

    rhm_poker #(.WINDOW_BITS(WINDOW_BITS)) u_poker (
        .clk(clk), .clr(clr), .acc(acc), .bit_i(bit_in), .last(last), .fail(alarm.poker)
    );

    rhm_runs #(.WINDOW_BITS(WINDOW_BITS)) u_runs (
        .clk(clk), .clr(clr), .acc(acc), .bit_i(bit_in), .last(last), .fail(alarm.runs)
    );

    rhm_run_detect #(.LONG_RUN_LEN(LONG_RUN_LEN), .NOISE_LEN(NOISE_LEN)) u_cont (
        .clk(clk), .clr(clr), .acc(acc), .bit_i(bit_in),
        .fail_long(alarm.long_run), .fail_noise(alarm.noise)
    );

    assign alarm.monobit = mono_q;

    assign fail_monobit  = alarm.monobit;
    assign fail_poker    = alarm.poker;
    assign fail_runs     = alarm.runs;
    assign fail_long_run = alarm.long_run;
    assign fail_noise    = alarm.noise;

    AST_POS_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc |=> (alarm == '0)); // R2
    AST_VERDICT_AT_END: assert property (@(posedge clk) disable iff (rst)
        (fail_monobit || fail_poker || fail_runs) |-> ($past(pos_q) == LAST_POS && $past(acc))); // R2
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (pos_q == '0 && ones_q == '0)); // R9

endmodule

// File: tb/tb_rng_health_mon.sv
module tb_rng_health_mon;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 20000;

    logic clk = 1'b0;
    logic rst, enable, bit_in, bit_valid;
    logic fail_monobit, fail_poker, fail_runs, fail_long_run, fail_noise;

    int vectors = 0;
    int errors  = 0;

    bit win_bits [WIN];
    int win_n   = 0;
    int cont_len = 0;
    bit cont_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rng_health_mon dut (
        .clk(clk), .rst(rst), .enable(enable), .bit_in(bit_in), .bit_valid(bit_valid),
        .fail_monobit(fail_monobit), .fail_poker(fail_poker), .fail_runs(fail_runs),
        .fail_long_run(fail_long_run), .fail_noise(fail_noise)
    );

    function automatic bit mono_bad();
        int ones = 0;
        for (int i = 0; i < WIN; i++) ones += int'(win_bits[i]);
        return (ones < 9655) || (ones > 10345);
    endfunction

    function automatic bit poker_bad();
        int c [16];
        bit bad = 1'b0;
        for (int v = 0; v < 16; v++) c[v] = 0;
        for (int k = 0; k < WIN/4; k++) begin
            int nibv;
            nibv = 8*int'(win_bits[4*k]) + 4*int'(win_bits[4*k+1])
                 + 2*int'(win_bits[4*k+2]) + int'(win_bits[4*k+3]);
            c[nibv]++;
        end
        for (int v = 0; v < 16; v++) if (c[v] < 240 || c[v] > 385) bad = 1'b1;
        return bad;
    endfunction

    function automatic bit runs_bad();
        int c [12];
        int lo [6];
        int hi [6];
        int l;
        bit bad = 1'b0;
        lo[0] = 2315; hi[0] = 2685;
        lo[1] = 1114; hi[1] = 1386;
        lo[2] = 527;  hi[2] = 723;
        lo[3] = 240;  hi[3] = 384;
        lo[4] = 103;  hi[4] = 209;
        lo[5] = 103;  hi[5] = 209;
        for (int i = 0; i < 12; i++) c[i] = 0;
        l = 1;
        for (int i = 1; i < WIN; i++) begin
            if (win_bits[i] == win_bits[i-1]) l++;
            else begin
                c[6*int'(win_bits[i-1]) + ((l > 6) ? 5 : l-1)]++;
                l = 1;
            end
        end
        c[6*int'(win_bits[WIN-1]) + ((l > 6) ? 5 : l-1)]++;
        for (int i = 0; i < 12; i++) if (c[i] < lo[i%6] || c[i] > hi[i%6]) bad = 1'b1;
        return bad;
    endfunction

    task automatic cmp(input logic act, input logic exp_v, input string what);
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp_v, $time);
        end
    endtask

    // one cycle: drive at negedge, sample at following negedge
    task automatic step(input logic b, input logic v, input logic en);
        logic e_mono, e_pok, e_run, e_long, e_noise;
        int old;
        e_mono = 0; e_pok = 0; e_run = 0; e_long = 0; e_noise = 0;
        enable = en; bit_in = b; bit_valid = v;
        if (!en) begin
            cont_len = 0; win_n = 0;
        end else if (v) begin
            old = cont_len;
            if (old != 0 && b == cont_prev) begin
                if (old < 48) cont_len = old + 1;
            end else cont_len = 1;
            cont_prev = b;
            e_long  = (cont_len == 34) && (old != 34);
            e_noise = (cont_len == 48) && (old != 48);
            win_bits[win_n] = b;
            win_n++;
            if (win_n == WIN) begin
                e_mono = mono_bad();
                e_pok  = poker_bad();
                e_run  = runs_bad();
                win_n  = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        vectors++;
        cmp(fail_monobit,  e_mono,  "R3 fail_monobit");
        cmp(fail_poker,    e_pok,   "R4 fail_poker");
        cmp(fail_runs,     e_run,   "R5 fail_runs");
        cmp(fail_long_run, e_long,  "R6 fail_long_run");
        cmp(fail_noise,    e_noise, "R7 fail_noise");
    endtask

    task automatic do_reset();
        rst = 1'b1; bit_valid = 1'b0; enable = 1'b1;
        repeat (3) @(negedge clk);
        cont_len = 0; win_n = 0;
        vectors++;
        if ({fail_monobit, fail_poker, fail_runs, fail_long_run, fail_noise} !== 5'b0) begin
            errors++;
            $display("FAIL R1 outputs in reset actual=%b expected=00000",
                {fail_monobit, fail_poker, fail_runs, fail_long_run, fail_noise});
        end
        rst = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        rst = 1'b1; enable = 1'b0; bit_in = 1'b0; bit_valid = 1'b0;
        @(negedge clk);
        do_reset();                                         // R1

        // R9: disabled monitor ignores a long stream of ones
        for (int i = 0; i < 64; i++) step(1'b1, 1'b1, 1'b0);
        // R9: a disable gap splits a run, so 30+10 ones raise nothing
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 1'b1);
        // R1: reset in the middle of a run clears the run count
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b1);
        do_reset();
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1);
        // R9: partial window, then discard it
        for (int i = 0; i < 5000; i++) step(1'($urandom), 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0);

        // R2/R3/R4/R5: random window with valid gaps, ends in 20 ones
        n = 0;
        while (n < WIN) begin
            logic v;
            v = ($urandom % 10) != 0;
            step((n >= WIN - 20) ? 1'b1 : 1'($urandom), v, 1'b1);
            if (v) n++;
        end
        // R8: 20 more ones across the boundary, then a 50-bit zero run (R6, R7)
        for (int i = 0; i < WIN; i++) begin
            logic b;
            if (i < 20) b = 1'b1;
            else if (i >= 5000 && i < 5050) b = 1'b0;
            else b = 1'($urandom);
            step(b, 1'b1, 1'b1);
        end
        // R3/R4/R5: heavily biased window
        for (int i = 0; i < WIN; i++) step(1'(($urandom % 8) != 0), 1'b1, 1'b1);
        // R4/R5: alternating window, balanced ones but failing groups and runs
        for (int i = 0; i < WIN; i++) step(1'(i % 2), 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule